// File: doc/BRIEF.md
# Codec Serial Port with Autobuffering

This block is the processor side of a synchronous serial link to a two-channel audio codec. The codec supplies the serial clock. The port sees it through a two-flop synchronizer running on a faster system clock. Words are 16 bits and travel MSB first. Each word in each direction is announced by its own active-high frame sync, which is sampled one serial clock before the MSB.

On the receive side, words land in numbered buffer slots. With autobuffering on, a single receive interrupt fires once the programmed number of words has arrived, so one sample period's pair of channel words costs one interrupt. With autobuffering off, every word raises its own interrupt and reports the slot it went to. An overrun flag catches an interrupt that arrives before the previous one was acknowledged.

The transmit side has two modes. In loopback mode the codec's incoming frame sync also starts each transmit word, and one word goes out per frame. A queued control word displaces that period's DAC update. In non-loopback mode the port drives its own transmit frame sync and sends as many words as it has. Every queued control word goes out before the DAC update word.

Top module: `codec_serial_port`

## Requirements
- R1: The serial clock is only an input. The port samples serial inputs on falling serial clock edges, after a two-flop synchronizer, and changes its serial outputs only on rising edges.
- R2: A receive word is 16 bits, MSB first. Its first bit is taken on the falling edge after the one where the receive frame sync is sampled high. A new frame sync is accepted while idle or on the falling edge that takes the LSB.
- R3: With autobuffering on, received words fill slots 0 to N-1 in order. One interrupt fires with the word in slot N-1, reporting slot N-1. N is the programmed count clamped to 1..SLOTS, and a count of 0 acts as 1. Any slot can be read back through the read index port.
- R4: With autobuffering off, each received word raises an interrupt. The reported slot index cycles 0, 1, ..., N-1, 0.
- R5: The receive interrupt is a pulse one system clock wide.
- R6: The overrun flag sets when an interrupt fires while the previous one is still unacknowledged. An acknowledge pulse clears both the pending state and the overrun flag.
- R7: In loopback mode the transmit frame sync is an input. The output enable is low, the frame sync output stays low, and a transmit word starts when the input frame sync is sampled high.
- R8: In non-loopback mode the output enable is high. The port raises its frame sync for one serial clock before each transmit MSB, and only when it has a word to send.
- R9: In non-loopback mode, all queued control words are sent before a pending DAC word. The DAC word is sent exactly once.
- R10: In loopback mode each transmit frame carries one word. It is the queue head if the queue is not empty, and a pending DAC word is then discarded. Otherwise it is the pending DAC word, or else the last DAC word sent again.
- R11: The control queue holds CQ_DEPTH words. The full flag is high at that count, and a push while full is ignored.
- R12: After reset the interrupt, overrun, frame sync output, serial data output and full flag are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the codec |
| rfs_i | input | 1 | Receive frame sync |
| dr_i | input | 1 | Receive serial data |
| tfs_i | input | 1 | Transmit frame sync in loopback mode |
| tfs_o | output | 1 | Transmit frame sync driven in non-loopback mode |
| tfs_oe_o | output | 1 | Output enable for the transmit frame sync |
| dt_o | output | 1 | Transmit serial data |
| loopback_i | input | 1 | 1 selects loopback mode |
| abuf_en_i | input | 1 | 1 enables autobuffering |
| abuf_cnt_i | input | $clog2(SLOTS+1) | Words per autobuffer interrupt |
| rx_irq_o | output | 1 | Receive interrupt pulse |
| rx_slot_o | output | $clog2(SLOTS) | Slot of the latest received word |
| rx_ovr_o | output | 1 | Receive overrun flag |
| rx_ack_i | input | 1 | Interrupt acknowledge pulse |
| rd_idx_i | input | $clog2(SLOTS) | Buffer slot read index |
| rd_data_o | output | WORD_W | Buffer slot contents |
| ctrl_push_i | input | 1 | Push a control word |
| ctrl_data_i | input | WORD_W | Control word |
| ctrl_full_o | output | 1 | Control queue full |
| dac_wr_i | input | 1 | Write a DAC update word |
| dac_data_i | input | WORD_W | DAC update word |

## Verification
The bench writes the DAC word before the control words and expects the control words on the wire first. A port that ranked by arrival would send the DAC sample early. In loopback it queues a control word on top of a pending DAC update and then runs an empty frame. A design that only delayed the update, instead of dropping it, would send the new sample where the old one must repeat. It also drives autobuffer counts of 0 and of more than SLOTS, pushes past the queue depth, and receives a second buffer without acknowledging the first. Mistakes there show up as missing or extra interrupts, a fifth control word on the wire, or an overrun flag that never sets.

// File: rtl/codec_serial_port.sv
module codec_serial_port #(
  parameter int WORD_W   = 16,
  parameter int SLOTS    = 4,
  parameter int CQ_DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sclk_i,
  input  logic                         rfs_i,
  input  logic                         dr_i,
  input  logic                         tfs_i,
  output logic                         tfs_o,
  output logic                         tfs_oe_o,
  output logic                         dt_o,
  input  logic                         loopback_i,
  input  logic                         abuf_en_i,
  input  logic [$clog2(SLOTS+1)-1:0]   abuf_cnt_i,
  output logic                         rx_irq_o,
  output logic [$clog2(SLOTS)-1:0]     rx_slot_o,
  output logic                         rx_ovr_o,
  input  logic                         rx_ack_i,
  input  logic [$clog2(SLOTS)-1:0]     rd_idx_i,
  output logic [WORD_W-1:0]            rd_data_o,
  input  logic                         ctrl_push_i,
  input  logic [WORD_W-1:0]            ctrl_data_i,
  output logic                         ctrl_full_o,
  input  logic                         dac_wr_i,
  input  logic [WORD_W-1:0]            dac_data_i
);
  localparam int IW = $clog2(SLOTS);
  localparam int CW = $clog2(SLOTS + 1);
  localparam int QW = $clog2(CQ_DEPTH);
  localparam int BW = $clog2(WORD_W + 1);

  logic [2:0] sck;
  logic [1:0] rfs_s, dr_s, tfi_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck   <= '0;
      rfs_s <= '0;
      dr_s  <= '0;
      tfi_s <= '0;
    end else begin
      sck   <= {sck[1:0], sclk_i};
      rfs_s <= {rfs_s[0], rfs_i};
      dr_s  <= {dr_s[0], dr_i};
      tfi_s <= {tfi_s[0], tfs_i};
    end

  wire srise = sck[1] & ~sck[2];
  wire sfall = ~sck[1] & sck[2];

  logic [CW-1:0] n_eff;
  always_comb
    if (abuf_cnt_i == '0)                n_eff = CW'(1);
    else if (abuf_cnt_i > CW'(SLOTS))    n_eff = CW'(SLOTS);
    else                                 n_eff = abuf_cnt_i;

  // receive path
  logic [BW-1:0]     rx_left;
  logic [WORD_W-1:0] rx_sh;
  logic [IW-1:0]     rx_idx;
  logic              rx_pend;
  logic [WORD_W-1:0] buf_q [SLOTS];

  wire               idx_end = (CW'(rx_idx) == n_eff - CW'(1));
  wire               rx_done = sfall && (rx_left == BW'(1));
  wire [WORD_W-1:0]  rx_word = {rx_sh[WORD_W-2:0], dr_s[1]};
  wire               rx_fire = rx_done && (!abuf_en_i || idx_end);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_left   <= '0;
      rx_sh     <= '0;
      rx_idx    <= '0;
      rx_slot_o <= '0;
      rx_irq_o  <= 1'b0;
      rx_pend   <= 1'b0;
      rx_ovr_o  <= 1'b0;
    end else begin
      rx_irq_o <= rx_fire;
      if (sfall) begin
        if (rx_left != '0) begin
          rx_sh   <= rx_word;
          rx_left <= rx_left - BW'(1);
        end
        if (rx_left <= BW'(1) && rfs_s[1]) rx_left <= BW'(WORD_W);
      end
      if (rx_done) begin
        rx_slot_o <= rx_idx;
        rx_idx    <= idx_end ? '0 : rx_idx + IW'(1);
      end
      if (rx_ack_i) begin
        rx_pend  <= 1'b0;
        rx_ovr_o <= 1'b0;
      end
      if (rx_fire) begin
        rx_pend <= 1'b1;
        if (rx_pend && !rx_ack_i) rx_ovr_o <= 1'b1;
      end
    end

  always_ff @(posedge clk)
    if (rx_done) buf_q[rx_idx] <= rx_word;

  assign rd_data_o = buf_q[rd_idx_i];

  // control word queue
  logic [WORD_W-1:0] cq_mem [CQ_DEPTH];
  logic [QW-1:0]     cq_wp, cq_rp;
  logic [QW:0]       cq_cnt;
  logic              cq_pop;

  assign ctrl_full_o = (cq_cnt == (QW+1)'(CQ_DEPTH));
  wire cq_has  = (cq_cnt != '0);
  wire cq_push = ctrl_push_i && !ctrl_full_o;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cq_wp  <= '0;
      cq_rp  <= '0;
      cq_cnt <= '0;
    end else begin
      if (cq_push) cq_wp <= (cq_wp == QW'(CQ_DEPTH-1)) ? '0 : cq_wp + QW'(1);
      if (cq_pop)  cq_rp <= (cq_rp == QW'(CQ_DEPTH-1)) ? '0 : cq_rp + QW'(1);
      case ({cq_push, cq_pop})
        2'b10:   cq_cnt <= cq_cnt + (QW+1)'(1);
        2'b01:   cq_cnt <= cq_cnt - (QW+1)'(1);
        default: cq_cnt <= cq_cnt;
      endcase
    end

  always_ff @(posedge clk)
    if (cq_push) cq_mem[cq_wp] <= ctrl_data_i;

  // transmit path
  logic [WORD_W-1:0] tx_sh, tx_hold, dac_new, dac_last;
  logic [BW-1:0]     tx_left;
  logic              tx_go, dac_pend;

  wire tx_free  = !tx_go && (tx_left <= BW'(1));
  wire nl_start = srise && !loopback_i && tx_free && (cq_has || dac_pend);
  wire lb_start = sfall && loopback_i && tfi_s[1] && tx_free;
  wire tx_start = nl_start || lb_start;
  assign cq_pop = tx_start && cq_has;

  wire [WORD_W-1:0] tx_pick = cq_has ? cq_mem[cq_rp] : (dac_pend ? dac_new : dac_last);

  assign tfs_oe_o = ~loopback_i;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tfs_o    <= 1'b0;
      dt_o     <= 1'b0;
      tx_sh    <= '0;
      tx_hold  <= '0;
      tx_left  <= '0;
      tx_go    <= 1'b0;
      dac_new  <= '0;
      dac_last <= '0;
      dac_pend <= 1'b0;
    end else begin
      if (srise) begin
        tfs_o <= nl_start;
        if (tx_go) begin
          dt_o    <= tx_hold[WORD_W-1];
          tx_sh   <= {tx_hold[WORD_W-2:0], 1'b0};
          tx_left <= BW'(WORD_W-1);
          tx_go   <= 1'b0;
        end else if (tx_left != '0) begin
          dt_o    <= tx_sh[WORD_W-1];
          tx_sh   <= {tx_sh[WORD_W-2:0], 1'b0};
          tx_left <= tx_left - BW'(1);
        end
      end
      if (tx_start) begin
        tx_hold <= tx_pick;
        tx_go   <= 1'b1;
        if (!cq_has) begin
          if (dac_pend) dac_last <= dac_new;
          dac_pend <= 1'b0;
        end else if (loopback_i) begin
          dac_pend <= 1'b0;
        end
      end
      if (dac_wr_i) begin
        dac_new  <= dac_data_i;
        dac_pend <= 1'b1;
      end
    end
endmodule

// File: rtl/codec_serial_port_sva.sv
module codec_serial_port_sva #(
  parameter int SLOTS = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       loopback_i,
  input logic                       abuf_en_i,
  input logic [$clog2(SLOTS+1)-1:0] abuf_cnt_i,
  input logic                       rx_irq_o,
  input logic [$clog2(SLOTS)-1:0]   rx_slot_o,
  input logic                       rx_ovr_o,
  input logic                       rx_ack_i,
  input logic                       tfs_o
);
  localparam int CW = $clog2(SLOTS + 1);

  logic [CW-1:0] n;
  always_comb
    if (abuf_cnt_i == '0)             n = CW'(1);
    else if (abuf_cnt_i > CW'(SLOTS)) n = CW'(SLOTS);
    else                              n = abuf_cnt_i;

  p_irq_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq_o |=> !rx_irq_o);

  p_abuf_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_irq_o && abuf_en_i) |-> (CW'(rx_slot_o) == n - CW'(1)));

  p_slot_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq_o |-> (CW'(rx_slot_o) < n));

  p_ovr_on_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ovr_o) |-> rx_irq_o);

  p_ovr_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rx_ack_i) && !rx_irq_o) |-> !rx_ovr_o);

  p_tfs_nonloop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tfs_o) |-> !loopback_i);
endmodule

bind codec_serial_port codec_serial_port_sva #(.SLOTS(SLOTS)) u_sva (
  .clk(clk), .rst_n(rst_n), .loopback_i(loopback_i), .abuf_en_i(abuf_en_i),
  .abuf_cnt_i(abuf_cnt_i), .rx_irq_o(rx_irq_o), .rx_slot_o(rx_slot_o),
  .rx_ovr_o(rx_ovr_o), .rx_ack_i(rx_ack_i), .tfs_o(tfs_o)
);

// File: tb/tb_codec_serial_port.sv
module tb_codec_serial_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, rfs = 1'b0, dr = 1'b0, tfs_in = 1'b0;
  logic loopback = 1'b0, abuf_en = 1'b0, rx_ack = 1'b0;
  logic [2:0] abuf_cnt = 3'd2;
  logic [1:0] rd_idx = 2'd0;
  logic ctrl_push = 1'b0, dac_wr = 1'b0;
  logic [15:0] ctrl_data = '0, dac_data = '0;
  logic tfs_o, tfs_oe, dt_o, rx_irq, rx_ovr, ctrl_full;
  logic [1:0] rx_slot;
  logic [15:0] rd_data;

  always #10 clk = ~clk;

  codec_serial_port dut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .rfs_i(rfs), .dr_i(dr), .tfs_i(tfs_in),
    .tfs_o(tfs_o), .tfs_oe_o(tfs_oe), .dt_o(dt_o), .loopback_i(loopback),
    .abuf_en_i(abuf_en), .abuf_cnt_i(abuf_cnt), .rx_irq_o(rx_irq), .rx_slot_o(rx_slot),
    .rx_ovr_o(rx_ovr), .rx_ack_i(rx_ack), .rd_idx_i(rd_idx), .rd_data_o(rd_data),
    .ctrl_push_i(ctrl_push), .ctrl_data_i(ctrl_data), .ctrl_full_o(ctrl_full),
    .dac_wr_i(dac_wr), .dac_data_i(dac_data)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  bit exp_irq = 0, exp_ovr = 0, m_pend = 0;
  int exp_slot = 0, m_idx = 0, r_left = 0, c_left = 0;
  logic [15:0] r_sh = '0, c_sh = '0, m_new = '0, m_last = '0;
  bit m_dpend = 0;
  logic [15:0] exp_tx[$];
  logic [15:0] m_cq[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int neff();
    if (abuf_cnt == 0) return 1;
    if (abuf_cnt > 4) return 4;
    return int'(abuf_cnt);
  endfunction

  always @(negedge clk) begin
    check(rx_irq == exp_irq, "R5 irq", rx_irq, exp_irq);
    if (exp_irq) check(int'(rx_slot) == exp_slot, "R3/R4 slot", rx_slot, exp_slot);
    check(rx_ovr == exp_ovr, "R6 ovr", rx_ovr, exp_ovr);
    check(tfs_oe == !loopback, "R7/R8 oe", tfs_oe, !loopback);
    if (loopback) check(tfs_o == 1'b0, "R7 tfs_o", tfs_o, 0);
    exp_irq = 0;
  end

  task automatic model_fall();
    logic fs_t;
    // receive side (R2)
    if (r_left > 0) begin
      r_sh = {r_sh[14:0], dr};
      r_left--;
      if (r_left == 0) begin
        if (!abuf_en || m_idx == neff() - 1) begin
          exp_irq = 1;
          exp_slot = m_idx;
          if (m_pend) exp_ovr = 1;
          m_pend = 1;
        end
        m_idx = (m_idx == neff() - 1) ? 0 : m_idx + 1;
      end
    end
    if (r_left == 0 && rfs) r_left = 16;
    // codec decoding of the transmit line (R1)
    fs_t = loopback ? tfs_in : tfs_o;
    if (c_left > 0) begin
      c_sh = {c_sh[14:0], dt_o};
      c_left--;
      if (c_left == 0) begin
        if (exp_tx.size() == 0) check(0, "R1 R9/R10 unexpected tx word", c_sh, 0);
        else begin
          logic [15:0] e;
          e = exp_tx.pop_front();
          check(c_sh == e, loopback ? "R1 R10 tx word" : "R1 R9 tx word", c_sh, e);
        end
      end
    end
    if (c_left == 0 && fs_t) c_left = 16;
    // loopback word choice (R10)
    if (loopback && tfs_in) begin
      if (m_cq.size() != 0) begin
        exp_tx.push_back(m_cq.pop_front());
        m_dpend = 0;
      end else if (m_dpend) begin
        m_last = m_new; m_dpend = 0;
        exp_tx.push_back(m_new);
      end else exp_tx.push_back(m_last);
    end
  endtask

  task automatic sc(input logic fr, input logic ft, input logic d);
    @(negedge clk) begin sclk = 1; rfs = fr; tfs_in = ft; dr = d; end
    repeat (3) @(posedge clk);
    @(negedge clk) sclk = 0;
    repeat (3) @(posedge clk);
    #1 model_fall();
  endtask

  task automatic frame(input logic [15:0] w, input logic ft);
    sc(1, ft, 0);
    for (int i = 15; i >= 0; i--) sc(0, 0, w[i]);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) sc(0, 0, 0);
  endtask

  task automatic push_ctrl(input logic [15:0] w);
    @(negedge clk) begin ctrl_push = 1; ctrl_data = w; end
    if (m_cq.size() < 4) m_cq.push_back(w);
    @(negedge clk) ctrl_push = 0;
  endtask

  task automatic dac_write(input logic [15:0] w);
    @(negedge clk) begin dac_wr = 1; dac_data = w; end
    m_new = w; m_dpend = 1;
    @(negedge clk) dac_wr = 0;
  endtask

  task automatic ack();
    @(negedge clk) rx_ack = 1;
    @(posedge clk) #1 begin m_pend = 0; exp_ovr = 0; end
    @(negedge clk) rx_ack = 0;
  endtask

  task automatic check_buf(input int idx, input logic [15:0] e);
    @(negedge clk) rd_idx = idx[1:0];
    #1 check(rd_data == e, "R2/R3 buffer slot", rd_data, e);
  endtask

  task automatic do_reset(input logic lb, input logic en, input logic [2:0] cnt);
    @(negedge clk) begin
      rst_n = 0; loopback = lb; abuf_en = en; abuf_cnt = cnt;
      exp_irq = 0; exp_ovr = 0; m_pend = 0; m_idx = 0; r_left = 0; c_left = 0;
      m_dpend = 0; m_last = '0; m_new = '0;
      exp_tx.delete(); m_cq.delete();
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(tfs_o == 0, "R12 tfs_o", tfs_o, 0);
    check(dt_o == 0, "R12 dt_o", dt_o, 0);
    check(ctrl_full == 0, "R12 full", ctrl_full, 0);
    check(rx_irq == 0 && rx_ovr == 0, "R12 irq/ovr", {rx_irq, rx_ovr}, 0);
  endtask

  task automatic tx_drained(input string req);
    check(exp_tx.size() == 0, req, exp_tx.size(), 0);
  endtask

  initial begin
    // autobuffer pair, non-loopback ordering, overrun
    do_reset(0, 1, 3'd2);
    dac_write(16'hD00D);
    push_ctrl(16'hC001);
    push_ctrl(16'hC002);
    exp_tx.push_back(16'hC001); exp_tx.push_back(16'hC002); exp_tx.push_back(16'hD00D);
    frame(16'h1234, 0);
    frame(16'hABCD, 0);
    check_buf(0, 16'h1234);
    check_buf(1, 16'hABCD);
    idle(30);
    tx_drained("R9 R8 nonloop order");
    frame(16'h5A5A, 0);
    frame(16'h0F0F, 0);
    check(rx_ovr == 1, "R6 overrun set", rx_ovr, 1);
    ack();
    check(rx_ovr == 0, "R6 overrun cleared", rx_ovr, 0);
    check_buf(0, 16'h5A5A);
    check_buf(1, 16'h0F0F);

    // autobuffer off: one interrupt per word, slot cycles (R4)
    do_reset(0, 0, 3'd3);
    for (int k = 0; k < 4; k++) begin
      frame(16'h1000 + k, 0);
      ack();
    end

    // count 0 acts as 1, count above SLOTS clamps (R3)
    do_reset(0, 1, 3'd0);
    frame(16'h2222, 0); ack();
    frame(16'h3333, 0); ack();
    check_buf(0, 16'h3333);
    do_reset(0, 1, 3'd7);
    for (int k = 0; k < 4; k++) frame(16'h4000 + k, 0);
    check_buf(3, 16'h4003);
    ack();

    // queue depth (R11)
    do_reset(0, 1, 3'd2);
    for (int k = 0; k < 4; k++) begin
      push_ctrl(16'hE000 + k);
      exp_tx.push_back(16'hE000 + k);
    end
    check(ctrl_full == 1, "R11 full high", ctrl_full, 1);
    push_ctrl(16'hEEEE);
    idle(75);
    tx_drained("R11 fifth push ignored");
    check(ctrl_full == 0, "R11 full low after drain", ctrl_full, 0);

    // loopback word selection (R7, R10)
    do_reset(1, 1, 3'd2);
    frame(16'h0101, 1);
    dac_write(16'hA5A5);
    frame(16'h0202, 1);
    frame(16'h0303, 1);
    ack();
    dac_write(16'h7777);
    push_ctrl(16'hC0DE);
    frame(16'h0404, 1);
    frame(16'h0505, 1);
    ack();
    push_ctrl(16'hBEEF);
    frame(16'h0606, 1);
    idle(2);
    tx_drained("R10 R7 loopback words");
    check(rx_ovr == 0, "R6 no overrun with ack", rx_ovr, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule